// File: doc/BRIEF.md
# Electronic Shutter Sequencer

This block decides, line by line, when a CCD image sensor's substrate shutter pulse is requested, and when the exposure window opens and closes. It sits behind the sync generator. It receives a strobe at the first line of each field and a strobe at every later line start. From a shutter setting and two control bits, it produces four outputs: a per-line shutter pulse request, a readout strobe that ends each exposure, an exposure-active flag, and a busy flag. Placing pulse edges within a line and driving the high-voltage levels are left to downstream logic.

An exposure is built from a sequence of one or more fields. With a field count of zero, the sequence is one field long and every field carries the shutter pulses (fast shutter). With a field count of N ≥ 1, the sequence spans N+1 fields and the pulses appear only in the field whose index matches the pulse-field setting (slow shutter). In every field that carries pulses, the pulses fall on lines 0 through H, where H is the line-count setting. The exposure therefore starts after the last pulse and runs to the next readout. The shutter setting is captured when a sequence starts and is held until that sequence has been read out. The busy flag marks a multi-field sequence in progress, so that upstream register logic can defer its commits.

Top module: `esh_sequencer`

## Requirements
- R1: While `rst_n` is low, and after its release until the first field strobe, `sub_req`, `readout`, `expo` and `busy` are all 0.
- R2: With `shut_en` = 0 when a sequence starts, the line-count, field-count and pulse-field inputs have no effect. No `sub_req` is issued, every field is a one-field sequence ended by `readout`, and `expo` is 1 from the first field onward.
- R3: In a field that carries pulses, `sub_req` is a one-cycle pulse after the strobe of each line whose index (0 at the field strobe, +1 per line strobe) is at most H. That makes H+1 pulses per field.
- R4: `shd_in` carries H in bits [SHD_W-1:0]. Its top bit, `shd_in[SHD_W]`, is reserved and ignored.
- R5: A sequence spans `svd_in`+1 fields. The first field strobe after reset starts a sequence without a readout. Each later sequence start is marked by a one-cycle `readout` after the field strobe that ends the previous sequence.
- R6: With `svd_in` ≥ 1, pulses are issued only in the field whose index (0 for the first field of the sequence) equals `spl_in`. If `spl_in` exceeds `svd_in`, the sequence has no pulses. With `svd_in` = 0, every field carries pulses.
- R7: `expo` falls at a sequence start if that sequence will issue pulses. It is 0 on every pulse line except the last and rises with the last pulse. When the sequence issues no pulses, `expo` is set to 1 at the sequence start and stays 1.
- R8: When a sequence's final field ends while `rd_hold` is 1, no `readout` is issued. The sequence then waits without pulses, with `expo` unchanged, until a field strobe sees `rd_hold` = 0. That strobe issues the readout and starts the next sequence.
- R9: `busy` is 1 from the start of a sequence with `svd_in` ≥ 1 until the strobe that reads it out. It is 0 during fast-shutter and disabled sequences.
- R10: `shut_en`, `svd_in`, `shd_in` and `spl_in` are sampled only at a sequence start. Changes during a sequence take effect at the next sequence start.
- R11: Every output change is registered on the clock edge that samples the field or line strobe causing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| field_stb | input | 1 | One-cycle strobe at the start of line 0 of a field |
| line_stb | input | 1 | One-cycle strobe at the start of each later line |
| shut_en | input | 1 | Shutter enable; 0 ignores the shutter setting |
| rd_hold | input | 1 | Suppresses the readout that ends a sequence |
| svd_in | input | SVD_W | Extra fields in the sequence (0 = fast shutter) |
| shd_in | input | SHD_W+1 | Last pulse line H in low bits; top bit reserved |
| spl_in | input | SPL_W | Index of the field that carries pulses in a slow sequence |
| sub_req | output | 1 | Shutter pulse request for the current line |
| readout | output | 1 | One-cycle strobe: sequence read out |
| expo | output | 1 | Exposure active |
| busy | output | 1 | Multi-field sequence in progress |

## Verification
All four outputs have a latency of exactly one register stage. A change caused by a strobe becomes visible on the edge that samples the strobe. The bench holds each strobe for one cycle starting at a falling edge. It reads `sub_req`, `expo`, `readout` and `busy` at the next falling edge, which is half a cycle after the capturing edge. It reads them again one cycle later, in an idle gap, to confirm that the pulses lasted a single cycle. Each field's per-line samples are stored and then compared as a whole with the pulse lines and exposure rise line that the requirements predict. This covers fast, slow, out-of-range, held and reconfigured sequences.

// File: rtl/esh_seq_pkg.sv
package esh_seq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_RUN  = 2'd1,
      SQ_HOLD = 2'd2
   } sq_state_e;
endpackage

// File: rtl/esh_field_seq.sv
module esh_field_seq
   import esh_seq_pkg::*;
#(
   parameter int SVD_W = 10,
   parameter int SHD_W = 11,
   parameter int SPL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             field_stb,
   input  logic             rd_hold,
   input  logic             cfg_en,
   input  logic [SVD_W-1:0] cfg_svd,
   input  logic [SHD_W-1:0] cfg_shd,
   input  logic [SPL_W-1:0] cfg_spl,
   output logic             pf_eff,
   output logic [SHD_W-1:0] shd_eff,
   output logic             seq_start,
   output logic             seq_has_pulse,
   output logic             readout,
   output logic             busy
);
   localparam int CMP_W = (SVD_W > SPL_W) ? SVD_W : SPL_W;

   sq_state_e        st_q, st_d;
   logic [SVD_W-1:0] fidx_q, fidx_d, fidx_inc, svd_used;
   logic [SVD_W-1:0] l_svd;
   logic [SHD_W-1:0] l_shd;
   logic [SPL_W-1:0] l_spl;
   logic             l_en;
   logic             pf_q, pf_d;
   logic             rd_q, rd_d;
   logic             busy_q, busy_d;
   logic             last_fld;
   logic             start;

   // Field index of the current sequence; a disabled sequence is one field long
   assign svd_used = l_en ? l_svd : '0;
   assign last_fld = (fidx_q == svd_used);
   assign fidx_inc = fidx_q + 1'b1;

   always_comb begin
      st_d   = st_q;
      fidx_d = fidx_q;
      pf_d   = pf_q;
      rd_d   = 1'b0;
      busy_d = busy_q;
      start  = 1'b0;
      if (field_stb) begin
         unique case (st_q)
            SQ_IDLE: start = 1'b1;
            SQ_RUN: begin
               if (last_fld) begin
                  if (rd_hold) begin
                     st_d = SQ_HOLD;
                     pf_d = 1'b0;
                  end else begin
                     start = 1'b1;
                     rd_d  = 1'b1;
                  end
               end else begin
                  fidx_d = fidx_inc;
                  pf_d   = l_en && (l_svd != '0) &&
                           (CMP_W'(fidx_inc) == CMP_W'(l_spl));
               end
            end
            SQ_HOLD: begin
               if (!rd_hold) begin
                  start = 1'b1;
                  rd_d  = 1'b1;
               end
            end
            default: start = 1'b1;
         endcase
      end
      if (start) begin
         st_d   = SQ_RUN;
         fidx_d = '0;
         pf_d   = cfg_en && ((cfg_svd == '0) || (cfg_spl == '0));
         busy_d = cfg_en && (cfg_svd != '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         fidx_q <= '0;
         pf_q   <= 1'b0;
         rd_q   <= 1'b0;
         busy_q <= 1'b0;
         l_en   <= 1'b0;
         l_svd  <= '0;
         l_shd  <= '0;
         l_spl  <= '0;
      end else begin
         st_q   <= st_d;
         fidx_q <= fidx_d;
         pf_q   <= pf_d;
         rd_q   <= rd_d;
         busy_q <= busy_d;
         if (start) begin
            l_en  <= cfg_en;
            l_svd <= cfg_svd;
            l_shd <= cfg_shd;
            l_spl <= cfg_spl;
         end
      end
   end

   // Look-ahead: the line-0 decision uses the values the strobe edge loads
   assign pf_eff        = field_stb ? pf_d : pf_q;
   assign shd_eff       = start ? cfg_shd : l_shd;
   assign seq_start     = start;
   assign seq_has_pulse = cfg_en &&
                          ((cfg_svd == '0) || (CMP_W'(cfg_spl) <= CMP_W'(cfg_svd)));
   assign readout       = rd_q;
   assign busy          = busy_q;
endmodule

// File: rtl/esh_line_gen.sv
module esh_line_gen #(
   parameter int SHD_W    = 11,
   parameter int LCNT_W   = 12,
   parameter bit LINE_SAT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             field_stb,
   input  logic             line_stb,
   input  logic             pf_eff,
   input  logic [SHD_W-1:0] shd_eff,
   output logic             hit,
   output logic             hit_last,
   output logic             sub_req
);
   localparam logic [LCNT_W-1:0] LCNT_MAX = {LCNT_W{1'b1}};

   logic [LCNT_W-1:0] lcnt_q, lcnt_nx, idx;
   logic              strobe;
   logic              sub_q;

   generate
      if (LINE_SAT) begin : g_sat
         assign lcnt_nx = (lcnt_q == LCNT_MAX) ? lcnt_q : lcnt_q + 1'b1;
      end else begin : g_wrap
         assign lcnt_nx = lcnt_q + 1'b1;
      end
   endgenerate

   assign strobe   = field_stb || line_stb;
   assign idx      = field_stb ? '0 : lcnt_nx;
   assign hit      = strobe && pf_eff && (idx <= LCNT_W'(shd_eff));
   assign hit_last = hit && (idx == LCNT_W'(shd_eff));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcnt_q <= '0;
         sub_q  <= 1'b0;
      end else begin
         if (strobe) lcnt_q <= idx;
         sub_q <= hit;
      end
   end

   assign sub_req = sub_q;
endmodule

// File: rtl/esh_expo_flag.sv
module esh_expo_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic hit_last,
   input  logic seq_start,
   input  logic seq_has_pulse,
   output logic expo
);
   logic expo_q;

   // A pulse line outranks the sequence start: the last pulse opens the window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         expo_q <= 1'b0;
      else if (hit)       expo_q <= hit_last;
      else if (seq_start) expo_q <= !seq_has_pulse;
   end

   assign expo = expo_q;
endmodule

// File: rtl/esh_sequencer.sv
module esh_sequencer #(
   parameter int SVD_W    = 10,
   parameter int SHD_W    = 11,
   parameter int SPL_W    = 10,
   parameter int LCNT_W   = 12,
   parameter bit LINE_SAT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           field_stb,
   input  logic           line_stb,
   input  logic           shut_en,
   input  logic           rd_hold,
   input  logic [SVD_W-1:0] svd_in,
   input  logic [SHD_W:0]   shd_in,
   input  logic [SPL_W-1:0] spl_in,
   output logic           sub_req,
   output logic           readout,
   output logic           expo,
   output logic           busy
);
   generate
      if (SVD_W < 1 || SPL_W < 1 || SHD_W < 1) begin : g_bad_width
         $error("esh_sequencer: field widths must be at least 1");
      end
      if (LCNT_W <= SHD_W) begin : g_bad_lcnt
         $error("esh_sequencer: line counter must be wider than the line-count field");
      end
   endgenerate

   logic             pf_eff;
   logic [SHD_W-1:0] shd_eff;
   logic             seq_start, seq_has_pulse;
   logic             hit, hit_last;
   logic             rsvd_unused;

   assign rsvd_unused = shd_in[SHD_W];

   esh_field_seq #(
      .SVD_W(SVD_W), .SHD_W(SHD_W), .SPL_W(SPL_W)
   ) i_field_seq (
      .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .rd_hold(rd_hold),
      .cfg_en(shut_en), .cfg_svd(svd_in), .cfg_shd(shd_in[SHD_W-1:0]),
      .cfg_spl(spl_in), .pf_eff(pf_eff), .shd_eff(shd_eff),
      .seq_start(seq_start), .seq_has_pulse(seq_has_pulse),
      .readout(readout), .busy(busy)
   );

   esh_line_gen #(
      .SHD_W(SHD_W), .LCNT_W(LCNT_W), .LINE_SAT(LINE_SAT)
   ) i_line_gen (
      .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .line_stb(line_stb),
      .pf_eff(pf_eff), .shd_eff(shd_eff), .hit(hit), .hit_last(hit_last),
      .sub_req(sub_req)
   );

   esh_expo_flag i_expo_flag (
      .clk(clk), .rst_n(rst_n), .hit(hit), .hit_last(hit_last),
      .seq_start(seq_start), .seq_has_pulse(seq_has_pulse), .expo(expo)
   );
endmodule

// File: rtl/esh_sequencer_chk.sv
module esh_sequencer_chk (
   input logic clk,
   input logic rst_n,
   input logic field_stb,
   input logic line_stb,
   input logic rd_hold,
   input logic sub_req,
   input logic readout,
   input logic expo,
   input logic busy
);
   AST_REQ_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      sub_req |-> $past(field_stb || line_stb));                        // R3
   AST_RD_ON_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      readout |-> $past(field_stb));                                     // R5
   AST_RD_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      readout |-> !$past(rd_hold));                                      // R8
   AST_BUSY_AT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(busy) |-> $past(field_stb));                              // R9
   AST_EXPO_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(expo) |-> $past(field_stb || line_stb));                  // R11
   AST_EXPO_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(expo) |-> (readout || sub_req));                             // R7
endmodule

bind esh_sequencer esh_sequencer_chk i_esh_sequencer_chk (.*);

// File: tb/test_esh_sequencer.sv
module test_esh_sequencer;
   localparam int CLK_P = 10;
   localparam int LPF   = 12;
   localparam int SVD_W = 10;
   localparam int SHD_W = 11;
   localparam int SPL_W = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic field_stb = 1'b0, line_stb = 1'b0, shut_en = 1'b0, rd_hold = 1'b0;
   logic [SVD_W-1:0] svd_in = '0;
   logic [SHD_W:0]   shd_in = '0;
   logic [SPL_W-1:0] spl_in = '0;
   logic sub_req, readout, expo, busy;

   int n_chk = 0, n_err = 0;
   bit pulse_at [LPF];
   bit expo_at  [LPF];
   bit f_rd, f_busy, f_wide, f_rd_bad;

   always #(CLK_P/2) clk = ~clk;

   esh_sequencer i_esh_sequencer (
      .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .line_stb(line_stb),
      .shut_en(shut_en), .rd_hold(rd_hold), .svd_in(svd_in), .shd_in(shd_in),
      .spl_in(spl_in), .sub_req(sub_req), .readout(readout), .expo(expo),
      .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // One field: strobe, sample half a cycle after the capturing edge, idle gap
   task automatic run_field();
      f_wide = 0; f_rd_bad = 0;
      for (int l = 0; l < LPF; l++) begin
         if (l == 0) field_stb = 1'b1; else line_stb = 1'b1;
         @(negedge clk);
         field_stb = 1'b0; line_stb = 1'b0;
         pulse_at[l] = sub_req;
         expo_at[l]  = expo;
         if (l == 0) begin f_rd = readout; f_busy = busy; end
         else if (readout) f_rd_bad = 1;
         @(negedge clk);
         if (sub_req || readout) f_wide = 1;
      end
   endtask

   // Pulses expected on lines first..last (first < 0: none)
   task automatic chk_pulses(input string req, input int first, input int last);
      int bad = -1;
      for (int l = 0; l < LPF; l++)
         if (pulse_at[l] != (first >= 0 && l >= first && l <= last)) bad = l;
      chk(bad < 0 && !f_wide, req, bad, -1);
   endtask

   // Exposure flag expected 1 from line rise onward (rise = LPF: never)
   task automatic chk_expo(input string req, input int rise);
      int bad = -1;
      for (int l = 0; l < LPF; l++)
         if (expo_at[l] != (l >= rise)) bad = l;
      chk(bad < 0, req, bad, -1);
   endtask

   task automatic chk_field(input string req, input bit rd, input bit bz);
      chk(f_rd == rd && !f_rd_bad, {req, " readout"}, f_rd, rd);
      chk(f_busy == bz, {req, " busy"}, f_busy, bz);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk({sub_req, readout, expo, busy} == 4'b0, "R1 in reset",
          {sub_req, readout, expo, busy}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({sub_req, readout, expo, busy} == 4'b0, "R1 after release",
          {sub_req, readout, expo, busy}, 0);
   endtask

   task automatic t_disabled();
      shut_en = 0; svd_in = 3; shd_in = 5; spl_in = 0; rd_hold = 0;
      do_reset();
      run_field();
      chk_pulses("R2 first field", -1, -1);
      chk_expo("R2 first field", 0);
      chk_field("R5 first start", 0, 0);
      run_field();
      chk_pulses("R2 second field", -1, -1);
      chk_expo("R2 second field", 0);
      chk_field("R2 R11 second field", 1, 0);
   endtask

   task automatic t_high();
      shut_en = 1; svd_in = 0; spl_in = 7; shd_in = {1'b1, 11'd4}; rd_hold = 0;
      do_reset();
      run_field();
      chk_pulses("R3 R4 fast field 1", 0, 4);
      chk_expo("R7 fast field 1", 4);
      chk_field("R9 fast field 1", 0, 0);
      shd_in = 0;
      run_field();
      chk_pulses("R3 fast single pulse", 0, 0);
      chk_expo("R7 last pulse on line 0", 0);
      chk_field("R5 fast readout", 1, 0);
   endtask

   task automatic t_low();
      shut_en = 1; svd_in = 2; spl_in = 1; shd_in = 3; rd_hold = 0;
      do_reset();
      run_field();
      chk_pulses("R6 slow idx0", -1, -1);
      chk_expo("R7 slow idx0", LPF);
      chk_field("R9 slow idx0", 0, 1);
      run_field();
      chk_pulses("R6 slow idx1", 0, 3);
      chk_expo("R7 slow idx1", 3);
      chk_field("R5 slow idx1", 0, 1);
      run_field();
      chk_pulses("R6 slow idx2", -1, -1);
      chk_expo("R7 slow idx2", 0);
      chk_field("R5 slow idx2", 0, 1);
      run_field();
      chk_expo("R7 fall at readout", LPF);
      chk_field("R5 slow readout", 1, 1);
   endtask

   task automatic t_spl_out();
      shut_en = 1; svd_in = 1; spl_in = 5; shd_in = 2; rd_hold = 0;
      do_reset();
      run_field();
      chk_pulses("R6 spl beyond svd", -1, -1);
      chk_expo("R7 no pulse sequence", 0);
      svd_in = 0;
      run_field();
      chk_pulses("R10 svd change ignored", -1, -1);
      chk_field("R10 busy kept", 0, 1);
      run_field();
      chk_field("R9 busy ends", 1, 0);
      chk_pulses("R10 new setting used", 0, 2);
   endtask

   task automatic t_latch();
      shut_en = 1; svd_in = 2; spl_in = 2; shd_in = 2; rd_hold = 0;
      do_reset();
      run_field();
      svd_in = 0; spl_in = 0; shd_in = 7;
      run_field();
      chk_pulses("R10 latched idx1", -1, -1);
      run_field();
      chk_pulses("R10 latched shd", 0, 2);
      chk_expo("R10 latched expo", 2);
      run_field();
      chk_pulses("R10 next sequence", 0, 7);
      chk_field("R10 next sequence", 1, 0);
   endtask

   task automatic t_hold();
      shut_en = 1; svd_in = 0; spl_in = 0; shd_in = 2; rd_hold = 0;
      do_reset();
      run_field();
      rd_hold = 1;
      run_field();
      chk_pulses("R8 held field", -1, -1);
      chk_expo("R8 held expo", 0);
      chk_field("R8 held field", 0, 0);
      run_field();
      chk_field("R8 still held", 0, 0);
      rd_hold = 0;
      run_field();
      chk_field("R8 released", 1, 0);
      chk_pulses("R8 released pulses", 0, 2);
      chk_expo("R8 released expo", 2);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      t_reset();
      t_disabled();
      t_high();
      t_low();
      t_spl_out();
      t_latch();
      t_hold();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule